// File: doc/BRIEF.md
# Address Translator with Translation Cache

This block turns virtual addresses from one processor port into physical addresses. The virtual address is split into a page number and an in-page offset. The page number is first looked up in a small, fully associative cache of page-table entries. On a hit, the physical address is returned on the next cycle and memory is not touched.

On a miss, the block reads one entry from a single-level page table in memory. The entry's address is formed from a base register plus the page number scaled by the entry size. If the entry is valid, its physical page number is joined to the unchanged offset and the entry is cached. If the entry is invalid, the block reports a page fault and returns no address.

Writing the base register, or pulsing the flush input, empties the cache in one cycle. A miss that is still in flight at that moment finishes with the base it started with, but its entry is not kept.

Top module: `tlb_xlate`

## Requirements
- R1: The low PAGE_BITS bits (default 12) of `req_va` are the offset and the rest are the virtual page number. On every successful response, `rsp_pa` equals the physical page number concatenated with the unchanged offset.
- R2: A request that hits in the cache is answered with `rsp_valid` high on the cycle after it is accepted, and no memory read is issued for it.
- R3: A miss issues exactly one memory read, at address `base + vpn*4`. `mem_req_valid` stays high with `mem_req_addr` stable until `mem_req_ready` is seen.
- R4: A table entry is PPN_W+1 bits wide: the top bit is valid and the rest is the physical page number. For a valid entry, `rsp_valid` is high with `rsp_fault` low on the cycle after `mem_rsp_valid`, and the entry is cached.
- R5: For an invalid entry, the response has `rsp_fault` high and `rsp_pa` zero. The entry is not cached, so the same page misses again.
- R6: `req_ready` is low from the cycle after a miss is accepted until the cycle its response is presented.
- R7: A fill goes to the lowest-numbered empty slot. When all slots are full, it goes to a round-robin slot that starts at 0 after reset and moves forward by one on each replacement. A page is never cached twice.
- R8: A cycle with `flush` or `base_we` high empties the whole cache. `base_we` also loads `base_wdata`. A request accepted in that same cycle counts as a miss and uses the base held before the write.
- R9: If `flush` or `base_we` occurs while a miss is in flight, the miss still completes with its original entry address and response. Its entry is not cached.
- R10: After reset, `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, the cache is empty and the base is BASE_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | VA_W | Virtual address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Page fault for this response |
| rsp_pa | output | PA_W | Physical address (zero on fault) |
| base_we | input | 1 | Load base register and flush cache |
| base_wdata | input | PA_W | New page-table base |
| flush | input | 1 | Invalidate all cache entries |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | PPN_W+1 | Table entry: valid bit on top, PPN below |

## Verification
A hit response is due one clock edge after the edge that accepts the request. A miss raises `mem_req_valid` one edge after acceptance, and its response is due one edge after the edge that samples `mem_rsp_valid`. The bench keeps a behavioural model that steps on the same rising edges as the design, using the same inputs. It compares every output at the falling edge that follows, so each result is checked in the exact cycle it becomes due, with memory latencies that vary.

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 8,
  parameter logic [PA_W-1:0] BASE_RST = '0,
  localparam int VPN_W = VA_W - PAGE_BITS,
  localparam int PPN_W = PA_W - PAGE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_pa,
  input  logic             base_we,
  input  logic [PA_W-1:0]  base_wdata,
  input  logic             flush,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PPN_W:0]   mem_rsp_data
);
  localparam int IDX_W = $clog2(ENTRIES);
  typedef enum logic [1:0] {IDLE, FETCH, WAIT} st_t;

  st_t                   state;
  logic [ENTRIES-1:0]    ent_v;
  logic [VPN_W-1:0]      ent_vpn [ENTRIES];
  logic [PPN_W-1:0]      ent_ppn [ENTRIES];
  logic [IDX_W-1:0]      rr, hit_idx, free_idx, victim;
  logic [ENTRIES-1:0]    match;
  logic                  free_found, stale;
  logic [PA_W-1:0]       base_q, addr_q, base_rd_q;
  logic [VPN_W-1:0]      vpn_q;
  logic [PAGE_BITS-1:0]  off_q;

  wire [VPN_W-1:0] req_vpn  = req_va[VA_W-1:PAGE_BITS];
  wire             flush_now = flush | base_we;
  wire             accept    = req_valid & req_ready;
  wire             hit       = |match & ~flush_now;
  wire             fill      = state == WAIT & mem_rsp_valid & mem_rsp_data[PPN_W] & ~stale & ~flush_now;

  assign req_ready     = state == IDLE;
  assign mem_req_valid = state == FETCH;
  assign mem_req_addr  = addr_q;
  assign victim        = free_found ? free_idx : rr;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      match[i] = ent_v[i] && ent_vpn[i] == req_vpn;
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!ent_v[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
  end

  always_ff @(posedge clk)
    if (fill) begin
      ent_vpn[victim] <= vpn_q;
      ent_ppn[victim] <= mem_rsp_data[PPN_W-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= IDLE;
      ent_v     <= '0;
      rr        <= '0;
      base_q    <= BASE_RST;
      base_rd_q <= '0;
      addr_q    <= '0;
      vpn_q     <= '0;
      off_q     <= '0;
      stale     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      case (state)
        IDLE: if (req_valid) begin
          if (hit) begin
            rsp_valid <= 1'b1;
            rsp_pa    <= {ent_ppn[hit_idx], req_va[PAGE_BITS-1:0]};
          end else begin
            state     <= FETCH;
            vpn_q     <= req_vpn;
            off_q     <= req_va[PAGE_BITS-1:0];
            addr_q    <= base_q + (PA_W'(req_vpn) << 2);
            base_rd_q <= base_q;
            stale     <= flush_now;
          end
        end
        FETCH: if (mem_req_ready) state <= WAIT;
        WAIT: if (mem_rsp_valid) begin
          state     <= IDLE;
          rsp_valid <= 1'b1;
          if (mem_rsp_data[PPN_W]) rsp_pa <= {mem_rsp_data[PPN_W-1:0], off_q};
          else begin
            rsp_fault <= 1'b1;
            rsp_pa    <= '0;
          end
        end
        default: state <= IDLE;
      endcase
      if (fill) begin
        ent_v[victim] <= 1'b1;
        if (!free_found) rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
      if (flush_now && state != IDLE) stale <= 1'b1;
      if (flush_now) ent_v <= '0;
      if (base_we) base_q <= base_wdata;
    end

  assert_one_match_R7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  assert_entry_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr == base_rd_q + (PA_W'(vpn_q) << 2));
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |=> ent_v == '0);
  assert_fault_no_pa_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid && rsp_pa == '0);
  assert_rsp_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(accept) || $past(mem_rsp_valid && state == WAIT));
endmodule

// File: tb/tb_tlb_xlate.sv
module tb_tlb_xlate;
  localparam int ENT = 8;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, base_we = 0, flush = 0;
  logic [31:0] req_va = 0, base_wdata = 0;
  logic req_ready, rsp_valid, rsp_fault, mem_req_valid;
  logic [31:0] rsp_pa, mem_req_addr;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [20:0] mem_rsp_data = 0;

  tlb_xlate dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, hs = 0, misses = 0;
  int req_dly = 0, rsp_dly = 0;
  string phase = "R10 reset";

  int m_state; bit m_stale; logic [31:0] m_base, m_addr; logic [19:0] m_vpn; logic [11:0] m_off;
  bit mv[ENT]; logic [19:0] mvpn[ENT], mppn[ENT]; int m_rr;
  bit e_rv, e_ft; logic [31:0] e_pa; string tag;

  function automatic logic [20:0] pte(input logic [31:0] a);
    int w = int'(a >> 2);
    return {1'(w % 7 != 3), 20'(w * 13 + 'h3A5)};
  endfunction

  always @(posedge clk) begin
    int s, f;
    bit fn;
    if (!rst_n) begin
      m_state = 0; m_stale = 0; m_base = 0; m_addr = 0; m_rr = 0; e_rv = 0;
      foreach (mv[i]) mv[i] = 0;
    end else begin
      s = m_state; fn = flush | base_we; e_rv = 0;
      if (mem_req_valid && mem_req_ready) hs++;
      if (s == 0 && req_valid) begin
        f = -1;
        if (!fn) foreach (mv[i]) if (mv[i] && mvpn[i] == req_va[31:12]) f = i;
        if (f >= 0) begin
          e_rv = 1; e_ft = 0; e_pa = {mppn[f], req_va[11:0]}; tag = "R2 R1 hit";
        end else begin
          m_state = 1; m_vpn = req_va[31:12]; m_off = req_va[11:0];
          m_addr = m_base + {m_vpn, 2'b00}; m_stale = fn; misses++;
        end
      end else if (s == 1 && mem_req_ready) m_state = 2;
      else if (s == 2 && mem_rsp_valid) begin
        m_state = 0; e_rv = 1;
        if (mem_rsp_data[20]) begin
          e_ft = 0; e_pa = {mem_rsp_data[19:0], m_off}; tag = "R4 R1 fill";
          if (!m_stale && !fn) begin
            f = -1;
            for (int i = ENT - 1; i >= 0; i--) if (!mv[i]) f = i;
            if (f < 0) begin f = m_rr; m_rr = (m_rr + 1) % ENT; end
            mv[f] = 1; mvpn[f] = m_vpn; mppn[f] = mem_rsp_data[19:0];
          end
        end else begin
          e_ft = 1; e_pa = 0; tag = "R5 fault";
        end
      end
      if (fn && s != 0) m_stale = 1;
      if (fn) foreach (mv[i]) mv[i] = 0;
      if (base_we) m_base = base_wdata;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL [%s] %s got %h expected %h (cycle %0d)", phase, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk(req_ready == (m_state == 0), "R6 R10 req_ready", 32'(req_ready), 32'(m_state == 0));
    chk(mem_req_valid == (m_state == 1), "R3 mem_req_valid", 32'(mem_req_valid), 32'(m_state == 1));
    if (m_state == 1) chk(mem_req_addr == m_addr, "R3 mem_req_addr", mem_req_addr, m_addr);
    chk(rsp_valid == e_rv, "R2 R4 rsp_valid", 32'(rsp_valid), 32'(e_rv));
    if (rsp_valid && e_rv) begin
      chk(rsp_fault == e_ft, {tag, " rsp_fault"}, 32'(rsp_fault), 32'(e_ft));
      chk(rsp_pa == e_pa, {tag, " rsp_pa"}, rsp_pa, e_pa);
    end
  end

  always @(negedge clk) begin
    static int ms = 0, cnt = 0;
    case (ms)
      0: if (mem_req_valid) begin
           if (cnt >= req_dly) begin mem_req_ready = 1; mem_rsp_data = pte(mem_req_addr); ms = 1; end
           else cnt++;
         end
      1: begin mem_req_ready = 0; cnt = 0; ms = 2; end
      2: if (cnt >= rsp_dly) begin mem_rsp_valid = 1; ms = 3; end else cnt++;
      default: begin mem_rsp_valid = 0; cnt = 0; ms = 0; end
    endcase
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 100000) begin
    checks++; fails++;
    $display("FAIL [%s] watchdog expired got %0d expected <100000", phase, cyc);
    finish_run();
  end

  task automatic do_req(input logic [31:0] va, input bit fl = 0, input bit bw = 0, input logic [31:0] bd = 0);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_va = va; flush = fl; base_we = bw; base_wdata = bd;
    @(negedge clk);
    req_valid = 0; flush = 0; base_we = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    phase = "R1 R4 miss then R2 hit";
    for (int v = 1; v <= 3; v++) do_req({20'(v), 12'h1A0 + 12'(v)});
    for (int v = 1; v <= 2; v++) do_req({20'(v), 12'hFFF - 12'(v)});
    settle();
    phase = "R5 fault not cached";
    do_req({20'd3, 12'h004}); do_req({20'd3, 12'h008}); settle();
    phase = "R7 victim order";
    req_dly = 1; rsp_dly = 2;
    for (int v = 20; v < 34; v++) do_req({20'(v), 12'h123});
    for (int v = 20; v < 34; v++) do_req({20'(v), 12'h321});
    settle();
    phase = "R8 flush";
    do_req({20'd21, 12'h0}, 1); do_req({20'd21, 12'h0}); do_req({20'd22, 12'h0});
    do_req({20'd22, 12'h0}, 0, 1, 32'h0000_1000); do_req({20'd22, 12'h0}); settle();
    phase = "R9 flush in flight";
    rsp_dly = 3;
    do_req({20'd40, 12'h555});
    @(negedge clk); flush = 1; @(negedge clk); flush = 0;
    do_req({20'd40, 12'h556});
    do_req({20'd41, 12'h000});
    @(negedge clk); base_we = 1; base_wdata = 32'h0000_2000; @(negedge clk); base_we = 0;
    do_req({20'd41, 12'h004}); do_req({20'd41, 12'h008}); settle();
    phase = "R1 R7 random";
    for (int n = 0; n < 300; n++) begin
      req_dly = $urandom_range(0, 3); rsp_dly = $urandom_range(0, 3);
      do_req({20'($urandom_range(0, 15)), 12'($urandom)}, ($urandom_range(0, 19) == 0));
    end
    settle();
    phase = "R3 reads per miss";
    chk(hs == misses, "R3 memory read count", 32'(hs), 32'(misses));
    finish_run();
  end
endmodule